// File: doc/BRIEF.md
# I2C Bus Clear Recovery Engine

This block frees an I2C bus after a target device has been left holding SDA low, for example after a transfer was cut short. The host programs a recovery configuration: how many SCL pulses to send, whether to stop early once SDA is seen released, and whether to finish with a STOP condition. A second write that sets the start bit launches the sequence. The engine then toggles SCL through open-drain outputs with SDA released, and it samples SDA at the end of every high phase.

When the sequence ends, the engine releases both lines and raises a done flag in its interrupt status register. A separate status bit records whether SDA was ever seen high, which tells software whether the bus actually recovered. The done flag is cleared by writing 1 to it. A mask bit decides whether the flag reaches the interrupt pin. SCL timing comes from a programmable half-period in clock cycles. A device that stretches SCL low lengthens the high phase.

Top module: `bclr_engine`

## Requirements
- R1: After reset and whenever the engine is idle, `scl_oe` and `sda_oe` are 0 and `irq` is 0 until a done event. After reset the configuration register reads with a threshold of 9 in bits [23:16] and zeros elsewhere.
- R2: Register offsets are: configuration 0x00, recovery status 0x04, interrupt status 0x08, interrupt mask 0x0C, half-period 0x10. A configuration write with bit 0 set while idle starts a sequence on the next clock edge. A write with bit 0 clear only stores the fields.
- R3: Each recovery pulse holds `scl_oe` high for H cycles and then low for H cycles, with `sda_oe` at 0 throughout. H is the half-period register value, and 0 is treated as 1.
- R4: With configuration bit 1 clear, exactly N pulses are sent, where N is configuration bits [23:16]. A value of 0 is treated as 1.
- R5: With configuration bit 1 set, pulsing stops after the first high phase in which SDA is sampled high.
- R6: With configuration bit 2 set, the sequence ends in a STOP. SDA is pulled low while SCL is low, SCL is released, and SDA is released one half-period later. SDA is never pulled low while SCL is released. With bit 2 clear, `sda_oe` stays 0.
- R7: On completion, bit 11 of the interrupt status register becomes 1, configuration bit 0 reads 0, and both lines are released. Configuration bit 0 reads 1 while a sequence runs.
- R8: Recovery status bit 0 reads 1 after a sequence only if SDA was sampled high in at least one high phase. Otherwise it reads 0, and done is still raised.
- R9: Writing 1 to interrupt status bit 11 clears done. `irq` equals done AND interrupt mask bit 11.
- R10: Configuration writes made while a sequence runs are ignored. They change neither the pulse count nor the stored fields.
- R11: While `scl_i` is held low by another device during a high phase, the half-period count pauses. Each held cycle lengthens the sequence by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions watch properties that must hold on every cycle. SDA must never be pulled low while SCL is released, which would be a false START. The pulse counter must never pass its threshold. The stored configuration must stay frozen while a sequence runs. Done must follow every completion, and a write-one-to-clear must take effect.

Only the directed scenarios can show sequence-level results. These include the exact pulse count for a given release point of the target, early termination against a full run, the STOP shape, the status verdict, the masked interrupt, and the one-cycle-per-cycle effect of clock stretching.

// File: rtl/bclr_pkg.sv
// Package: shared register offsets, field positions and sequencer states
// for the bus clear engine. Assumes byte-addressed 32-bit registers.
package bclr_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] ADR_CFG  = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_IRQ  = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_MASK = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_DIV  = 5'h10;

    localparam int CFG_GO_BIT   = 0;
    localparam int CFG_TERM_BIT = 1;
    localparam int CFG_STOP_BIT = 2;
    localparam int CFG_THR_LSB  = 16;
    localparam int IRQ_DONE_BIT = 11;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOW    = 3'd1,
        ST_HIGH   = 3'd2,
        ST_STOP_A = 3'd3,
        ST_STOP_B = 3'd4,
        ST_FINISH = 3'd5
    } bclr_state_e;
endpackage

// File: rtl/bclr_tick.sv
// Module: half-period timer. Produces a one-cycle tick every H enabled,
// non-held cycles, where H is the programmed half-period (0 acts as 1).
// Assumes 'en' falls between sequences so each sequence starts aligned.
module bclr_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hold,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    // Terminal count of the divider.
    always_comb begin
        last = (half == '0) ? '0 : half - 1'b1;
        tick = en && !hold && (cnt == last);
    end

    // Count cycles within a half-period; pause on hold, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (!hold) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bclr_seq.sv
// Module: recovery sequencer. Alternates SCL low/high phases, samples SDA
// at the end of each high phase, counts pulses against the threshold and
// optionally builds a STOP before a one-cycle finish state.
// Assumes 'start' is only asserted while 'busy' is low.
module bclr_seq
    import bclr_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [THR_W-1:0] thr,
    input  logic             stop_en,
    input  logic             term_en,
    input  logic             tick,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             run,
    output logic             hold,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             finish,
    output logic             recovered
);
    bclr_state_e      state;
    logic [THR_W-1:0] pulse_cnt;
    logic [THR_W-1:0] thr_eff;
    logic             sda_hi_now;
    logic             last_pulse;

    // Decode phase outputs from the state.
    always_comb begin
        thr_eff    = (thr == '0) ? {{(THR_W-1){1'b0}}, 1'b1} : thr;
        scl_oe     = (state == ST_LOW) || (state == ST_STOP_A);
        sda_oe     = (state == ST_STOP_A) || (state == ST_STOP_B);
        busy       = (state != ST_IDLE);
        finish     = (state == ST_FINISH);
        run        = busy && !finish;
        hold       = (state == ST_HIGH) && !scl_i;
        sda_hi_now = sda_i;
        last_pulse = (pulse_cnt >= thr_eff) || (term_en && sda_hi_now);
    end

    // Advance through the phases and keep pulse count and SDA verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pulse_cnt <= '0;
            recovered <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_LOW;
                    pulse_cnt <= '0;
                    recovered <= 1'b0;
                end
                ST_LOW: if (tick) begin
                    pulse_cnt <= pulse_cnt + 1'b1;
                    state     <= ST_HIGH;
                end
                ST_HIGH: if (tick) begin
                    recovered <= recovered | sda_hi_now;
                    if (last_pulse) state <= stop_en ? ST_STOP_A : ST_FINISH;
                    else            state <= ST_LOW;
                end
                ST_STOP_A: if (tick) state <= ST_STOP_B;
                ST_STOP_B: if (tick) state <= ST_FINISH;
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    AST_NO_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe)) |-> !$rose(sda_oe)); // R6
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pulse_cnt <= thr_eff)); // R4
    AST_IDLE_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!scl_oe && !sda_oe && !busy)); // R7
endmodule

// File: rtl/bclr_regs.sv
// Module: register file. Holds configuration, half-period, mask, done flag
// and recovery status; issues the start pulse. Fields are frozen while the
// sequencer is busy. Read data is combinational from the address.
module bclr_regs
    import bclr_pkg::*;
#(
    parameter int THR_W   = 8,
    parameter int DIV_W   = 16,
    parameter int DEF_THR = 9,
    parameter int DEF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              finish,
    input  logic              rec_i,
    output logic              start,
    output logic [THR_W-1:0]  cfg_thr,
    output logic              cfg_stop,
    output logic              cfg_term,
    output logic [DIV_W-1:0]  div_half,
    output logic              irq
);
    logic done_q;
    logic mask_q;
    logic stat_q;
    logic cfg_wr;

    // Decode write strobes and the start request.
    always_comb begin
        cfg_wr = wr && (addr == ADR_CFG) && !busy;
        start  = cfg_wr && wdata[CFG_GO_BIT];
        irq    = done_q && mask_q;
    end

    // Configuration and half-period storage, frozen during a sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_thr  <= THR_W'(DEF_THR);
            cfg_stop <= 1'b0;
            cfg_term <= 1'b0;
            div_half <= DIV_W'(DEF_DIV);
        end else begin
            if (cfg_wr) begin
                cfg_thr  <= wdata[CFG_THR_LSB +: THR_W];
                cfg_stop <= wdata[CFG_STOP_BIT];
                cfg_term <= wdata[CFG_TERM_BIT];
            end
            if (wr && (addr == ADR_DIV) && !busy) div_half <= wdata[DIV_W-1:0];
        end
    end

    // Done flag (set on finish, write-one-to-clear), mask and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            mask_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            if (finish) done_q <= 1'b1;
            else if (wr && (addr == ADR_IRQ) && wdata[IRQ_DONE_BIT]) done_q <= 1'b0;
            if (wr && (addr == ADR_MASK)) mask_q <= wdata[IRQ_DONE_BIT];
            if (start)       stat_q <= 1'b0;
            else if (finish) stat_q <= rec_i;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CFG: begin
                rdata[CFG_THR_LSB +: THR_W] = cfg_thr;
                rdata[CFG_STOP_BIT]         = cfg_stop;
                rdata[CFG_TERM_BIT]         = cfg_term;
                rdata[CFG_GO_BIT]           = busy;
            end
            ADR_STAT: rdata[0]              = stat_q;
            ADR_IRQ:  rdata[IRQ_DONE_BIT]   = done_q;
            ADR_MASK: rdata[IRQ_DONE_BIT]   = mask_q;
            ADR_DIV:  rdata[DIV_W-1:0]      = div_half;
            default:  rdata                 = '0;
        endcase
    end

    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done_q); // R7
    AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADR_IRQ && wdata[IRQ_DONE_BIT] && !finish) |=> !done_q); // R9
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cfg_thr) && $stable(cfg_stop) && $stable(cfg_term))); // R10
endmodule

// File: rtl/bclr_engine.sv
// Module: top of the I2C bus clear engine. Connects the register file,
// the half-period timer and the recovery sequencer. Assumes scl_i/sda_i
// are already synchronised to clk; outputs are open-drain enables.
module bclr_engine
    import bclr_pkg::*;
#(
    parameter int THR_W   = 8,
    parameter int DIV_W   = 16,
    parameter int DEF_THR = 9,
    parameter int DEF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq
);
    logic             start, busy, finish, rec, run, hold, tick;
    logic             cfg_stop, cfg_term;
    logic [THR_W-1:0] cfg_thr;
    logic [DIV_W-1:0] div_half;

    bclr_regs #(
        .THR_W(THR_W), .DIV_W(DIV_W), .DEF_THR(DEF_THR), .DEF_DIV(DEF_DIV)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .finish(finish),
        .rec_i(rec), .start(start), .cfg_thr(cfg_thr), .cfg_stop(cfg_stop),
        .cfg_term(cfg_term), .div_half(div_half), .irq(irq)
    );

    bclr_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(run), .hold(hold),
        .half(div_half), .tick(tick)
    );

    bclr_seq #(.THR_W(THR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .thr(cfg_thr),
        .stop_en(cfg_stop), .term_en(cfg_term), .tick(tick),
        .scl_i(scl_i), .sda_i(sda_i), .run(run), .hold(hold),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .finish(finish),
        .recovered(rec)
    );
endmodule

// File: tb/bclr_engine_bench.sv
// Directed bench for the bus clear engine: a bus model with a target that
// releases SDA during a chosen SCL low phase and an optional SCL stretch.
module bclr_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl_i, sda_i, scl_oe, sda_oe, irq;

    int n_chk = 0;
    int n_bad = 0;

    // Bus and monitor state.
    int   release_at = 0;
    logic mon_clr = 1'b0;
    int   pulses, low_run, last_low, cyc;
    logic prev_scl, prev_sda, sda_used, stop_seen, bad_start, meas_on;
    logic stretch_req = 1'b0;
    logic stretch_used;
    int   st_cnt;
    int   stretch_len = 7;

    always #5 clk = ~clk;

    assign scl_i = !(scl_oe || (st_cnt != 0));
    assign sda_i = !(sda_oe || (pulses < release_at));

    bclr_engine u_bclr_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_i),
        .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    // Line monitor: pulses, low length, STOP shape, stretch, run length.
    always @(posedge clk) begin
        if (mon_clr) begin
            pulses <= 0; low_run <= 0; last_low <= 0; cyc <= 0;
            prev_scl <= 1'b0; prev_sda <= 1'b0; sda_used <= 1'b0;
            stop_seen <= 1'b0; bad_start <= 1'b0; stretch_used <= 1'b0;
            st_cnt <= 0;
        end else begin
            prev_scl <= scl_oe;
            prev_sda <= sda_oe;
            if (scl_oe && !prev_scl && !sda_oe) pulses <= pulses + 1;
            if (scl_oe && !sda_oe) low_run <= low_run + 1;
            if (!scl_oe && prev_scl && !prev_sda) begin
                last_low <= low_run; low_run <= 0;
            end
            if (sda_oe) sda_used <= 1'b1;
            if (prev_sda && !sda_oe && !scl_oe) stop_seen <= 1'b1;
            if (sda_oe && !prev_sda && !scl_oe && !prev_scl) bad_start <= 1'b1;
            if (stretch_req && prev_scl && !scl_oe && !stretch_used) begin
                st_cnt <= stretch_len; stretch_used <= 1'b1;
            end else if (st_cnt != 0) st_cnt <= st_cnt - 1;
            if (meas_on && !irq) cyc <= cyc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cfgw(input int thr, input bit stp, input bit trm, input bit go);
        return (32'(thr) << 16) | (32'(stp) << 2) | (32'(trm) << 1) | 32'(go);
    endfunction

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    // Run one sequence and wait for done; leaves done set.
    task automatic run_op(input int thr, input bit stp, input bit trm, input int rel, input int half);
        logic [31:0] v;
        wr(5'h10, 32'(half));
        wr(5'h00, cfgw(thr, stp, trm, 1'b0));
        release_at = rel;
        clear_mon();
        meas_on = 1'b1;
        wr(5'h00, cfgw(thr, stp, trm, 1'b1));
        for (int i = 0; i < 5000; i++) begin
            rd(5'h08, v);
            if (v[11]) break;
        end
        meas_on = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h00, v);
        chk(v == 32'h0009_0000, "R1 cfg reset", int'(v), 32'h0009_0000);
        chk(!scl_oe && !sda_oe && !irq, "R1 idle lines", {scl_oe, sda_oe, irq}, 0);
        rd(5'h04, v);
        chk(v == 0, "R1 status reset", int'(v), 0);
    endtask

    task automatic t_no_start();
        clear_mon();
        wr(5'h00, cfgw(5, 1, 0, 0));
        repeat (20) @(negedge clk);
        chk(pulses == 0 && !sda_used, "R2 no start without go", pulses, 0);
    endtask

    task automatic t_stuck();
        logic [31:0] v;
        run_op(9, 1, 0, 1000, 4);
        chk(pulses == 9, "R4 stuck pulse count", pulses, 9);
        chk(last_low == 4, "R3 low phase length", last_low, 4);
        chk(stop_seen, "R6 stop generated", stop_seen, 1);
        chk(!bad_start, "R6 no false start", bad_start, 0);
        rd(5'h04, v);
        chk(v[0] == 1'b0, "R8 stuck status", v[0], 0);
        rd(5'h00, v);
        chk(v == cfgw(9, 1, 0, 0), "R7 go self-clears", int'(v), int'(cfgw(9, 1, 0, 0)));
        chk(!scl_oe && !sda_oe, "R7 lines released", {scl_oe, sda_oe}, 0);
        wr(5'h08, 32'h800);
    endtask

    task automatic t_term();
        logic [31:0] v;
        run_op(9, 1, 1, 3, 4);
        chk(pulses == 3, "R5 terminate early", pulses, 3);
        rd(5'h04, v);
        chk(v[0] == 1'b1, "R8 recovered status", v[0], 1);
        wr(5'h08, 32'h800);
    endtask

    task automatic t_noterm();
        logic [31:0] v;
        run_op(6, 0, 0, 2, 2);
        chk(pulses == 6, "R4 full count despite release", pulses, 6);
        chk(!sda_used, "R6 no stop when disabled", sda_used, 0);
        chk(last_low == 2, "R3 low phase at H=2", last_low, 2);
        rd(5'h04, v);
        chk(v[0] == 1'b1, "R8 recovered without terminate", v[0], 1);
        wr(5'h08, 32'h800);
    endtask

    task automatic t_thr_zero();
        run_op(0, 0, 0, 1000, 0);
        chk(pulses == 1, "R4 zero threshold acts as one", pulses, 1);
        chk(last_low == 1, "R3 zero half-period acts as one", last_low, 1);
        wr(5'h08, 32'h800);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(5'h0C, 32'h0);
        run_op(2, 0, 0, 1000, 2);
        rd(5'h08, v);
        chk(v[11] && !irq, "R9 masked irq", irq, 0);
        wr(5'h0C, 32'h800);
        @(negedge clk);
        chk(irq, "R9 unmasked irq", irq, 1);
        wr(5'h08, 32'h800);
        rd(5'h08, v);
        chk(!v[11] && !irq, "R9 write one clears done", irq, 0);
    endtask

    task automatic t_busy_write();
        logic [31:0] v;
        wr(5'h10, 32'd4);
        wr(5'h00, cfgw(4, 1, 0, 0));
        release_at = 1000;
        clear_mon();
        wr(5'h00, cfgw(4, 1, 0, 1));
        repeat (6) @(negedge clk);
        wr(5'h00, cfgw(2, 0, 1, 1));
        for (int i = 0; i < 200; i++) begin
            rd(5'h08, v);
            if (v[11]) break;
        end
        chk(pulses == 4, "R10 busy write ignored count", pulses, 4);
        rd(5'h00, v);
        chk(v == cfgw(4, 1, 0, 0), "R10 fields unchanged", int'(v), int'(cfgw(4, 1, 0, 0)));
        wr(5'h08, 32'h800);
    endtask

    task automatic t_stretch();
        int base;
        wr(5'h0C, 32'h800);
        stretch_req = 1'b0;
        run_op(2, 0, 0, 1000, 4);
        base = cyc;
        wr(5'h08, 32'h800);
        stretch_req = 1'b1;
        run_op(2, 0, 0, 1000, 4);
        stretch_req = 1'b0;
        chk(cyc == base + stretch_len, "R11 stretch delays", cyc, base + stretch_len);
        wr(5'h08, 32'h800);
    endtask

    logic all_done = 1'b0;

    initial begin
        meas_on = 1'b0;
        mon_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_clr = 1'b0;
        t_reset();
        t_no_start();
        wr(5'h0C, 32'h800);
        t_stuck();
        t_term();
        t_noterm();
        t_thr_zero();
        t_irq();
        t_busy_write();
        t_stretch();
        all_done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!all_done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule